// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation converter. A byte-wide register bus sets the conversion clock, the resolution, the sample length, the trigger source and the input channel. The block then runs the binary search itself: it drives a trial code to an external DAC, samples the comparator's answer, and keeps or drops each bit from the most significant one down. The finished code is latched into a two-byte result register.

Software starts a conversion by writing the channel/control register, or arms a hardware trigger that starts one on a rising edge. Conversions run once or back to back. A completion flag, with an optional interrupt, reports each result. Reading the high result byte freezes the result pair until the low byte is read, so a conversion that ends between the two reads cannot tear the pair. Such a result is parked and moved in when the low byte is read.

Register addresses: 0 = channel/control (CTL), 1 = trigger/status (TRG), 2 = result high, 3 = result low, 4 = configuration (CFG).

Top module: `adc_ctrl`

## Requirements
- R1: After reset all five registers read 0x00, `irq` is low and no conversion is active.
- R2: CFG reads back every written bit: bit 7 low power (driven on `low_power`), bits 6:5 divide code, bit 4 long sample, bits 3:2 resolution, bits 1:0 clock select. TRG reads busy in bit 7, trigger select in bit 6 and the two compare bits in 5:4. Its bits 3:0 always read 0. CTL reads complete in bit 7, interrupt enable in bit 6, continuous in bit 5 and channel in bits 4:0.
- R3: The result is the binary-search code, right-justified (high byte bits 3:0, low byte bits 7:0), for resolution 2'b00 = 8 bits, 2'b01 = 12 bits, 2'b10 = 10 bits. `cmp_in` high means the input is at or above `dac_code`.
- R4: With clock select 2'b00, the complete flag is set r*(S+N) clock edges after the starting edge. Divide codes 00/01/10/11 give r = 1/2/4/8. S is 4, or 24 with long sample set. N is the resolution.
- R5: The busy flag TRG[7] is high from the start edge until the conversion ends.
- R6: With software trigger (TRG[6]=0), a CTL write aborts any running conversion and starts a full new one, and `chan_sel` shows the written channel.
- R7: With TRG[6]=1, a CTL write stops any conversion and starts none. Only a rising edge of `hw_trig` starts one, and a held-high `hw_trig` starts no further one.
- R8: With CTL[5]=1, a new conversion follows each completion without a gap, and the result register updates every S+N conversion clocks.
- R9: The complete flag clears on a CTL write, or on a low-byte read that releases no parked result. `irq` is high exactly while the flag and the interrupt enable are both set.
- R10: A high-byte read freezes both result bytes until the low-byte read. A result that completes meanwhile is parked and becomes visible after that read, with the complete flag still set.
- R11: Clock select 2'b01/2'b10/2'b11 counts `alt_tick[0]/[1]/[2]` as input clock pulses. With the selected tick held low, the conversion does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| alt_tick | input | 3 | Alternative input clock pulses |
| hw_trig | input | 1 | Hardware start trigger |
| cmp_in | input | 1 | Comparator answer for the current trial code |
| dac_code | output | 12 | Trial code to the DAC |
| chan_sel | output | 5 | Selected input channel |
| low_power | output | 1 | Low-power request to the analog side |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The hardest state to reach is a completion that lands while the result pair is frozen. It needs continuous mode running, a high-byte read at the right moment, and a change of the analog value before the next conversion ends. The bench models the analog input as a number compared against `dac_code`. It reads the high byte right after a completion, changes the modelled input, and waits long enough for further results. It then checks that the low byte still belongs to the frozen pair, and that the newer result appears after the low-byte read with the complete flag still set.

// File: rtl/adc_pkg.sv
package adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_TRIAL
  } seq_state_t;

  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_TRG  = 3'd1;
  localparam logic [2:0] A_RESH = 3'd2;
  localparam logic [2:0] A_RESL = 3'd3;
  localparam logic [2:0] A_CFG  = 3'd4;

  // divide code to ratio minus one
  function automatic logic [2:0] div_limit(input logic [1:0] code);
    return 3'((1 << code) - 1);
  endfunction

  // resolution code to bit count
  function automatic int unsigned res_bits(input logic [1:0] mode);
    case (mode)
      2'b01:   return 12;
      2'b10:   return 10;
      default: return 8;
    endcase
  endfunction

  function automatic int unsigned samp_len(input logic lng, input int unsigned short_len,
                                           input int unsigned long_len);
    return lng ? long_len : short_len;
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
  import adc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic [1:0] div_code,
  input  logic [2:0] alt_tick,
  input  logic       restart,
  output logic       conv_tick
);
  logic [2:0] cnt;
  logic       src;
  logic [2:0] lim;

  assign src = (clk_sel == 2'b00) ? 1'b1 : alt_tick[clk_sel - 2'd1];
  assign lim = div_limit(div_code);
  assign conv_tick = src && (cnt == lim) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (src)     cnt <= (cnt == lim) ? 3'd0 : cnt + 3'd1;
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int SHORT_SAMP = 4,
  parameter int LONG_SAMP  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             long_smp,
  input  logic             cont,
  input  logic [1:0]       mode,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  localparam int SAMP_W = $clog2(LONG_SAMP + 1);
  localparam int BI_W   = $clog2(RES_W);

  seq_state_t       state;
  logic [SAMP_W-1:0] scnt;
  logic [BI_W-1:0]   bidx;
  logic [RES_W-1:0]  acc;
  logic [RES_W-1:0]  trial;
  logic [RES_W-1:0]  keep;
  logic              samp_end;

  assign trial    = acc | (RES_W'(1) << bidx);
  assign keep     = cmp_in ? trial : acc;
  assign dac_code = (state == ST_TRIAL) ? trial : '0;
  assign samp_end = (scnt == SAMP_W'(samp_len(long_smp, SHORT_SAMP, LONG_SAMP) - 1));
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_TRIAL) && tick && (bidx == '0) && !start && !abort;
  assign result   = keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      scnt  <= '0;
      bidx  <= '0;
      acc   <= '0;
    end else if (start) begin
      state <= ST_SAMPLE;
      scnt  <= '0;
      acc   <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
    end else if (tick) begin
      case (state)
        ST_SAMPLE: begin
          if (samp_end) begin
            state <= ST_TRIAL;
            bidx  <= BI_W'(res_bits(mode) - 1);
            acc   <= '0;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        ST_TRIAL: begin
          acc <= keep;
          if (bidx == '0) begin
            state <= cont ? ST_SAMPLE : ST_IDLE;
            scnt  <= '0;
          end else begin
            bidx <= bidx - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_result.sv
module adc_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [RES_W-1:0] din,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             ctl_wr,
  output logic [RES_W-1:0] res_q,
  output logic             coco,
  output logic             lock
);
  logic [RES_W-1:0] shadow;
  logic             pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      shadow <= '0;
      pend   <= 1'b0;
      lock   <= 1'b0;
      coco   <= 1'b0;
    end else begin
      if (rd_hi) lock <= 1'b1;
      if (rd_lo && lock) begin
        lock <= 1'b0;
        pend <= 1'b0;
        if (pend && !done) res_q <= shadow;
      end
      if (done) begin
        if (lock && !rd_lo) begin
          shadow <= din;
          pend   <= 1'b1;
        end else begin
          res_q <= din;
        end
      end
      if (done)                           coco <= 1'b1;
      else if (ctl_wr || (rd_lo && !pend)) coco <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int CH_W       = 5,
  parameter int SHORT_SAMP = 4,
  parameter int LONG_SAMP  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [2:0]       alt_tick,
  input  logic             hw_trig,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  chan_sel,
  output logic             low_power,
  output logic             irq
);
  localparam int HI_W = RES_W - 8;

  logic [7:0]       cfg;
  logic             aien, cont;
  logic [CH_W-1:0]  chan;
  logic             trg, cmp_en, cmp_gt;
  logic             hw_prev;

  logic             ctl_wr, rd_hi, rd_lo, hw_rise;
  logic             start_pulse, abort_pulse, conv_tick, conv_done, busy;
  logic [RES_W-1:0] conv_val, res_q;
  logic             coco, lock;

  assign ctl_wr      = bus_wr && (bus_addr == A_CTL);
  assign rd_hi       = bus_rd && (bus_addr == A_RESH);
  assign rd_lo       = bus_rd && (bus_addr == A_RESL);
  assign hw_rise     = hw_trig && !hw_prev;
  assign start_pulse = (ctl_wr && !trg) || (trg && hw_rise);
  assign abort_pulse = ctl_wr && trg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      aien    <= 1'b0;
      cont    <= 1'b0;
      chan    <= '0;
      trg     <= 1'b0;
      cmp_en  <= 1'b0;
      cmp_gt  <= 1'b0;
      hw_prev <= 1'b0;
    end else begin
      hw_prev <= hw_trig;
      if (bus_wr) begin
        case (bus_addr)
          A_CTL: begin
            aien <= bus_wdata[6];
            cont <= bus_wdata[5];
            chan <= bus_wdata[CH_W-1:0];
          end
          A_TRG: begin
            trg    <= bus_wdata[6];
            cmp_en <= bus_wdata[5];
            cmp_gt <= bus_wdata[4];
          end
          A_CFG: cfg <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  adc_clkdiv u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (cfg[1:0]),
    .div_code  (cfg[6:5]),
    .alt_tick  (alt_tick),
    .restart   (start_pulse),
    .conv_tick (conv_tick)
  );

  adc_seq #(
    .RES_W      (RES_W),
    .SHORT_SAMP (SHORT_SAMP),
    .LONG_SAMP  (LONG_SAMP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_pulse),
    .abort    (abort_pulse),
    .tick     (conv_tick),
    .long_smp (cfg[4]),
    .cont     (cont),
    .mode     (cfg[3:2]),
    .cmp_in   (cmp_in),
    .busy     (busy),
    .done     (conv_done),
    .dac_code (dac_code),
    .result   (conv_val)
  );

  adc_result #(.RES_W(RES_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (conv_done),
    .din    (conv_val),
    .rd_hi  (rd_hi),
    .rd_lo  (rd_lo),
    .ctl_wr (ctl_wr),
    .res_q  (res_q),
    .coco   (coco),
    .lock   (lock)
  );

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {coco, aien, cont, chan};
      A_TRG:   bus_rdata = {busy, trg, cmp_en, cmp_gt, 4'b0000};
      A_RESH:  bus_rdata = {{(8 - HI_W){1'b0}}, res_q[RES_W-1:8]};
      A_RESL:  bus_rdata = res_q[7:0];
      A_CFG:   bus_rdata = cfg;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign chan_sel  = chan;
  assign low_power = cfg[7];
  assign irq       = coco && aien;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_pulse,
  input logic             conv_done,
  input logic             busy,
  input logic             coco,
  input logic             lock,
  input logic             rd_lo,
  input logic             ctl_wr,
  input logic             trg,
  input logic             hw_trig,
  input logic             aien,
  input logic             irq,
  input logic [RES_W-1:0] res_q
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy); // R5

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done || ctl_wr)); // R5

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> coco); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (coco && aien)); // R9

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !rd_lo) |=> $stable(res_q)); // R10

  AST_HW_EDGE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && trg) |-> hw_trig); // R7
endmodule

bind adc_ctrl adc_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .conv_done   (conv_done),
  .busy        (busy),
  .coco        (coco),
  .lock        (lock),
  .rd_lo       (rd_lo),
  .ctl_wr      (ctl_wr),
  .trg         (trg),
  .hw_trig     (hw_trig),
  .aien        (aien),
  .irq         (irq),
  .res_q       (res_q)
);

// File: tb/adc_ctrl_test.sv
`timescale 1ns/1ps
module adc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  alt_tick = '0;
  logic        hw_trig = 1'b0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic [4:0]  chan_sel;
  logic        low_power, irq;
  logic [11:0] analog = '0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign cmp_in = (analog >= dac_code);

  adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_tick(alt_tick), .hw_trig(hw_trig),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel), .low_power(low_power),
    .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] peek(input logic [2:0] a);
    return 8'h00;
  endfunction

  task automatic look(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // counts edges until the complete flag is seen
  task automatic wait_flag(output int n);
    logic [7:0] d;
    n = 0;
    look(3'd0, d);
    while (!d[7] && n < 2000) begin
      @(posedge clk); #1;
      n++;
      look(3'd0, d);
    end
  endtask

  task automatic read_result(output logic [11:0] v);
    logic [7:0] h, l;
    rd(3'd2, h);
    rd(3'd3, l);
    v = {h[3:0], l};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      look(3'(a), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 irq reset", irq, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    int n;
    wr(3'd4, 8'hA5);
    look(3'd4, d);
    chk("R2 CFG readback", d, 8'hA5);
    chk("R2 low_power pin", low_power, 1);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    look(3'd1, d);
    chk("R2 TRG readback low bits zero", d, 8'h70);
    wr(3'd1, 8'h00);
    analog = 12'h055;
    wr(3'd0, 8'h5F);
    look(3'd0, d);
    chk("R2 CTL readback", d, 8'h5F);
    chk("R6 chan_sel", chan_sel, 31);
    wait_flag(n);
    wr(3'd0, 8'h00);
    wait_flag(n);
    read_result(d);
  endtask

  task automatic run_conv(input logic [7:0] cfg, input logic [11:0] v,
                          input int exp_n, input logic [11:0] exp_v, input string tag);
    logic [7:0] d;
    logic [11:0] r;
    int n;
    wr(3'd4, cfg);
    analog = v;
    wr(3'd0, 8'h01);
    look(3'd1, d);
    chk({"R5 busy at start ", tag}, d[7], 1);
    wait_flag(n);
    chk({"R4 cycles ", tag}, n, exp_n);
    look(3'd1, d);
    chk({"R5 busy after end ", tag}, d[7], 0);
    read_result(r);
    chk({"R3 result ", tag}, r, exp_v);
  endtask

  task automatic t_clksel;
    logic [7:0] d;
    int n;
    wr(3'd4, 8'h09);
    analog = 12'h1C3;
    wr(3'd0, 8'h01);
    tick_n(30);
    look(3'd1, d);
    chk("R11 stalled busy", d[7], 1);
    look(3'd0, d);
    chk("R11 stalled no flag", d[7], 0);
    alt_tick = 3'b001;
    wait_flag(n);
    chk("R11 cycles on alt tick", n, 14);
    alt_tick = 3'b000;
    read_result(d);
    wr(3'd4, 8'h08);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    int n;
    analog = 12'h0AA;
    wr(3'd0, 8'h41);
    chk("R9 irq low while running", irq, 0);
    wait_flag(n);
    chk("R9 irq with flag", irq, 1);
    rd(3'd2, d);
    rd(3'd3, d);
    look(3'd0, d);
    chk("R9 flag cleared by low read", d[7], 0);
    chk("R9 irq cleared", irq, 0);
    wr(3'd0, 8'h41);
    wait_flag(n);
    wr(3'd0, 8'h01);
    look(3'd0, d);
    chk("R9 flag cleared by CTL write", d[7], 0);
    wait_flag(n);
    read_result(d);
  endtask

  task automatic t_abort;
    logic [11:0] r;
    int n;
    wr(3'd4, 8'h18);
    analog = 12'h2E1;
    wr(3'd0, 8'h01);
    tick_n(10);
    wr(3'd0, 8'h07);
    chk("R6 new channel", chan_sel, 7);
    wait_flag(n);
    chk("R6 restart full length", n, 34);
    read_result(r);
    chk("R6 result after abort", r, 12'h2E1);
    wr(3'd4, 8'h08);
  endtask

  task automatic t_hw;
    logic [7:0] d;
    logic [11:0] r;
    int n;
    wr(3'd1, 8'h40);
    analog = 12'h3FF;
    wr(3'd0, 8'h01);
    tick_n(5);
    look(3'd1, d);
    chk("R7 CTL write does not start", d[7], 0);
    hw_trig = 1'b1;
    @(posedge clk); #1;
    wait_flag(n);
    chk("R7 hw start cycles", n, 14);
    read_result(r);
    chk("R7 hw result", r, 12'h3FF);
    tick_n(20);
    look(3'd1, d);
    chk("R7 held trigger no restart", d[7], 0);
    hw_trig = 1'b0;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_cont_lock;
    logic [7:0] d;
    int n;
    analog = 12'h100;
    wr(3'd0, 8'h21);
    wait_flag(n);
    look(3'd3, d);
    chk("R8 first result", d, 8'h00);
    analog = 12'h2AA;
    tick_n(14);
    look(3'd3, d);
    chk("R8 second result back to back", d, 8'hAA);
    look(3'd1, d);
    chk("R8 still busy", d[7], 1);
    rd(3'd2, d);
    chk("R10 high byte", d, 8'h02);
    analog = 12'h0F0;
    tick_n(30);
    look(3'd3, d);
    chk("R10 frozen low byte", d, 8'hAA);
    rd(3'd3, d);
    chk("R10 low byte read", d, 8'hAA);
    look(3'd3, d);
    chk("R10 parked result moved in", d, 8'hF0);
    look(3'd0, d);
    chk("R10 flag kept", d[7], 1);
    wr(3'd0, 8'h01);
    wait_flag(n);
    rd(3'd2, d);
    rd(3'd3, d);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick_n(3);
    rst_n = 1'b1;
    tick_n(2);
    t_reset();
    t_regs();
    run_conv(8'h08, 12'h2B5, 14, 12'h2B5, "10b div1");
    run_conv(8'h14, 12'hFFF, 36, 12'hFFF, "12b long");
    run_conv(8'h20, 12'h000, 24, 12'h000, "8b div2");
    run_conv(8'h68, 12'h155, 112, 12'h155, "10b div8");
    run_conv(8'h40, 12'h0C9, 48, 12'h0C9, "8b div4");
    t_clksel();
    t_irq();
    t_abort();
    t_hw();
    t_cont_lock();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule